// File: doc/BRIEF.md
# Binary-to-decimal ASCII converter

This block turns an unsigned binary integer (64 bits by default) into a fixed-width string of ASCII decimal digits (20 characters by default). It never divides by ten. The input is first scaled once into a binary fraction by multiplying it with a reciprocal power-of-ten constant, ceil(2^128 / 10^19) with 64 fraction bits. The integer part of that product is the leading decimal digit. Every later digit is the integer part that rises above the binary point when the remaining fraction is multiplied by ten.

The scaling multiply is iterative shift-and-add, one input bit per cycle, so no wide combinational multiplier is built. The truncated low-order product bits are rounded upward into a small guard field kept below the 64 fraction bits. The guard field carries the error margin that makes every digit exact. The fraction register is wider than the input by the guard bits plus a 4-bit overflow digit. Each multiply by ten is a shift-and-add done in one cycle.

A single start pulse launches a conversion. The digits come out most significant first, one byte per cycle, with a valid flag. A done pulse follows the last byte. Leading zeros are kept.

Top module: `bdc_ascii_conv`

## Requirements
- R1: Each conversion emits exactly 20 bytes. Each byte is 8'h30 plus a digit 0 to 9. Read in order, the bytes spell the zero-padded decimal value of the input, most significant digit first.
- R2: The first byte has out_valid high in the 66th cycle after the clock edge that accepts start (input width plus two). The 20 bytes occupy 20 consecutive cycles.
- R3: done is high for exactly one cycle. That is the cycle right after the last byte, and out_valid is low in it. done is never high together with out_valid.
- R4: start is ignored from the edge that accepts it up to and including the edge that raises done. Holding start high with a different value during that time changes neither the bytes nor causes a second conversion afterwards.
- R5: A synchronous active-high rst abandons any conversion. After the next edge, out_valid and done are low, and they stay low until a new start.
- R6: Values at decimal boundaries convert exactly. Examples are 10^19-1, 10^19, 10^18, 2^64-1, 9 and 10. The leading digit never exceeds the one allowed by the input width.
- R7: A start accepted in the cycle where done is high begins a new conversion with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion of value when idle |
| value | input | 64 | Unsigned binary number, sampled with start |
| out_char | output | 8 | ASCII digit byte |
| out_valid | output | 1 | out_char holds a digit this cycle |
| done | output | 1 | One-cycle pulse after the final digit |

## Verification
The digit-range and leading-digit assertions rely on the scaling constant having been rounded up and on the guard field holding at least one bit, so that the accumulated error stays below one unit of 10^-19. The start-ignored assertion assumes start and rst are synchronous levels sampled only at rising edges. The stimulus changes every input at the falling edge and holds value steady at the accepting edge. It raises start during a conversion only in the hold test, and it asserts rst only for whole cycles.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  localparam int unsigned BDC_IN_W  = 64;
  localparam int unsigned BDC_NDIG  = 20;
  localparam int unsigned BDC_GUARD = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_ROUND,
    ST_EMIT,
    ST_FIN
  } bdc_state_e;

  // 10^n in a wide container; valid while 10^n < 2^256
  function automatic logic [255:0] pow10(input int unsigned n);
    logic [255:0] p;
    p = 256'd1;
    for (int unsigned i = 0; i < n; i++) p = p * 256'd10;
    return p;
  endfunction

  // decimal digit 0..9 to its ASCII code (0x30 + d)
  function automatic logic [7:0] digit_to_ascii(input logic [3:0] d);
    return 8'h30 + {4'h0, d};
  endfunction

endpackage

// File: rtl/bdc_scale.sv
// Iterative scaling: acc = value * K, MSB of value first, one bit per cycle.
// frac_init is the product rounded upward to IN_W+GUARD fraction bits.
module bdc_scale #(
  parameter int unsigned IN_W  = bdc_pkg::BDC_IN_W,
  parameter int unsigned NDIG  = bdc_pkg::BDC_NDIG,
  parameter int unsigned GUARD = bdc_pkg::BDC_GUARD,
  localparam int unsigned FB   = IN_W + GUARD,
  localparam int unsigned FR_W = FB + 4
) (
  input  logic            clk,
  input  logic            load,
  input  logic [IN_W-1:0] value,
  input  logic            step,
  output logic [FR_W-1:0] frac_init
);

  localparam int unsigned KW  = IN_W + 1;
  localparam int unsigned PW  = 2 * IN_W + 1;
  localparam int unsigned CUT = IN_W - GUARD;
  localparam int unsigned TW  = PW - CUT;

  // ceil(2^(2*IN_W) / 10^(NDIG-1)): rounded up so the fraction never undershoots
  function automatic logic [KW-1:0] calc_k();
    logic [255:0] den;
    logic [255:0] num;
    den = bdc_pkg::pow10(NDIG - 1);
    num = 256'd1 << (2 * IN_W);
    num = (num + den - 256'd1) / den;
    return num[KW-1:0];
  endfunction

  localparam logic [KW-1:0] K = calc_k();

  logic [IN_W-1:0] xs;
  logic [PW-1:0]   acc;
  logic [TW:0]     rounded;
  logic            sticky;

  always_ff @(posedge clk) begin
    if (load) begin
      xs  <= value;
      acc <= '0;
    end else if (step) begin
      xs  <= xs << 1;
      acc <= (acc << 1) + (xs[IN_W-1] ? PW'(K) : '0);
    end
  end

  assign sticky    = |acc[CUT-1:0];
  assign rounded   = {1'b0, acc[PW-1:CUT]} + (TW+1)'(sticky);
  assign frac_init = FR_W'(rounded);

endmodule

// File: rtl/bdc_digits.sv
// Fraction register: multiply by ten each emit, overflow nibble is the digit.
module bdc_digits #(
  parameter int unsigned IN_W  = bdc_pkg::BDC_IN_W,
  parameter int unsigned NDIG  = bdc_pkg::BDC_NDIG,
  parameter int unsigned GUARD = bdc_pkg::BDC_GUARD,
  localparam int unsigned FB   = IN_W + GUARD,
  localparam int unsigned FR_W = FB + 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [FR_W-1:0] frac_in,
  input  logic            emit,
  output logic [7:0]      out_char,
  output logic            out_valid
);

  function automatic logic [FR_W-1:0] mul10(input logic [FB-1:0] f);
    logic [FR_W-1:0] w;
    w = FR_W'(f);
    return (w << 3) + (w << 1);
  endfunction

  // largest leading digit: (2^IN_W - 1) / 10^(NDIG-1)
  function automatic logic [3:0] calc_lead_max();
    logic [255:0] q;
    q = ((256'd1 << IN_W) - 256'd1) / bdc_pkg::pow10(NDIG - 1);
    return q[3:0];
  endfunction

  localparam logic [3:0] LEAD_MAX = calc_lead_max();

  logic [FR_W-1:0] fr;
  logic [3:0]      cur_digit;

  assign cur_digit = fr[FR_W-1:FB];

  always_ff @(posedge clk) begin
    if (load)      fr <= frac_in;
    else if (emit) fr <= mul10(fr[FB-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_char  <= 8'h00;
    end else begin
      out_valid <= emit;
      if (emit) out_char <= bdc_pkg::digit_to_ascii(cur_digit);
    end
  end

  // R1: every extracted overflow nibble is a decimal digit
  a_r1_digit_range: assert property (@(posedge clk) disable iff (rst)
    emit |-> (cur_digit <= 4'd9));

  // R6: the scaled value's integer part stays within the input width's range
  a_r6_lead_bound: assert property (@(posedge clk) disable iff (rst)
    load |-> (frac_in[FR_W-1:FB] <= LEAD_MAX));

endmodule

// File: rtl/bdc_ctrl.sv
// Sequencer: accept, IN_W scaling steps, one rounding load, NDIG emits, done.
module bdc_ctrl #(
  parameter int unsigned IN_W = bdc_pkg::BDC_IN_W,
  parameter int unsigned NDIG = bdc_pkg::BDC_NDIG
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load_x,
  output logic step,
  output logic load_f,
  output logic emit,
  output logic last_emit,
  output logic done
);
  import bdc_pkg::*;

  localparam int unsigned CNT_MAX = (IN_W > NDIG) ? IN_W : NDIG;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  bdc_state_e    state;
  logic [CW-1:0] cnt;
  logic          mul_last;

  assign mul_last  = (state == ST_MUL) && (cnt == CW'(IN_W - 1));
  assign load_x    = (state == ST_IDLE) && start;
  assign step      = (state == ST_MUL);
  assign load_f    = (state == ST_ROUND);
  assign emit      = (state == ST_EMIT);
  assign last_emit = emit && (cnt == CW'(NDIG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (start) begin state <= ST_MUL; cnt <= '0; end
        ST_MUL:   if (mul_last) begin state <= ST_ROUND; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
        ST_ROUND: begin state <= ST_EMIT; cnt <= '0; end
        ST_EMIT:  if (last_emit) state <= ST_FIN;
                  else cnt <= cnt + 1'b1;
        ST_FIN:   begin done <= 1'b1; state <= ST_IDLE; end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R4: a start seen while busy never restarts the scaling sequence
  a_r4_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> !(state == ST_MUL && cnt == '0));

  // R3: done comes exactly one cycle after the cycle holding the last byte
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last_emit, 2));

endmodule

// File: rtl/bdc_ascii_conv.sv
module bdc_ascii_conv #(
  parameter int unsigned IN_W  = bdc_pkg::BDC_IN_W,
  parameter int unsigned NDIG  = bdc_pkg::BDC_NDIG,
  parameter int unsigned GUARD = bdc_pkg::BDC_GUARD
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] value,
  output logic [7:0]      out_char,
  output logic            out_valid,
  output logic            done
);

  localparam int unsigned FR_W = IN_W + GUARD + 4;

  logic            load_x;
  logic            step;
  logic            load_f;
  logic            emit;
  logic            last_emit;
  logic [FR_W-1:0] frac_init;

  bdc_ctrl #(.IN_W(IN_W), .NDIG(NDIG)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load_x(load_x), .step(step), .load_f(load_f), .emit(emit),
    .last_emit(last_emit), .done(done)
  );

  bdc_scale #(.IN_W(IN_W), .NDIG(NDIG), .GUARD(GUARD)) u_scale (
    .clk(clk), .load(load_x), .value(value), .step(step),
    .frac_init(frac_init)
  );

  bdc_digits #(.IN_W(IN_W), .NDIG(NDIG), .GUARD(GUARD)) u_digits (
    .clk(clk), .rst(rst), .load(load_f), .frac_in(frac_init),
    .emit(emit), .out_char(out_char), .out_valid(out_valid)
  );

  // R3: valid bytes and the done pulse never overlap
  a_r3_valid_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && done));

  // R2: the byte stream only ends by handing over to done
  a_r2_stream_contig: assert property (@(posedge clk) disable iff (rst)
    ($fell(out_valid) && !$past(rst)) |-> done);

  // R5: reset clears the visible outputs at the next edge
  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !done));

endmodule

// File: tb/bdc_ascii_conv_tb.sv
module bdc_ascii_conv_tb;

  localparam int CLK_P = 10;
  localparam int IN_W  = 64;
  localparam int ND    = 20;
  localparam int LAT   = IN_W + 2;
  localparam int NV    = 10;

  localparam logic [63:0] VIN [NV] = '{
    64'd0, 64'd1, 64'd9, 64'd10,
    64'd9999999999999999999, 64'd10000000000000000000,
    64'd18446744073709551615, 64'd12345678901234567890,
    64'd999999999999999999, 64'd1000000000000000000
  };
  localparam logic [159:0] VEXP [NV] = '{
    "00000000000000000000", "00000000000000000001",
    "00000000000000000009", "00000000000000000010",
    "09999999999999999999", "10000000000000000000",
    "18446744073709551615", "12345678901234567890",
    "00999999999999999999", "01000000000000000000"
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [63:0] din;
  logic [7:0]  out_char;
  logic        out_valid;
  logic        done;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  bdc_ascii_conv u_dut (
    .clk(clk), .rst(rst), .start(start), .value(din),
    .out_char(out_char), .out_valid(out_valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] act, input logic [159:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference digits by repeated division and modulo
  function automatic logic [159:0] ref_str(input logic [63:0] v);
    logic [63:0]  r;
    logic [159:0] s;
    r = v;
    for (int i = 0; i < ND; i++) begin
      s[8*i +: 8] = 8'h30 + 8'(r % 64'd10);
      r = r / 64'd10;
    end
    return s;
  endfunction

  // entered at the falling edge right after the edge that accepted start
  task automatic collect(input logic [63:0] v, input logic [159:0] exp,
                         input bit hold, input bit chain,
                         input logic [63:0] nv, input string req);
    int t;
    bit strm_ok;
    logic [159:0] got;
    if (hold) begin start = 1'b1; din = ~v; end
    else start = 1'b0;
    t = 0;
    do begin @(negedge clk); t++; end while (!out_valid && t < 4*LAT);
    chk(t == LAT, "R2", "first byte latency", t, LAT);
    got = '0;
    strm_ok = 1'b1;
    for (int i = 0; i < ND; i++) begin
      if (i > 0) @(negedge clk);
      if (!out_valid || done) strm_ok = 1'b0;
      got = {got[151:0], out_char};
    end
    chk(strm_ok, "R2", "20 contiguous bytes", strm_ok, 1);
    chk(got == exp, req, "digit string", got, exp);
    @(negedge clk);
    chk(done && !out_valid, "R3", "done after last byte", {done, out_valid}, 2'b10);
    if (chain) begin start = 1'b1; din = nv; end
    else start = 1'b0;
    @(negedge clk);
    chk(!done, "R3", "done lasts one cycle", done, 0);
    if (chain) collect(nv, ref_str(nv), 1'b0, 1'b0, 64'd0, "R7");
    else if (hold) begin
      bit quiet = 1'b1;
      repeat (2*LAT) begin @(negedge clk); if (out_valid || done) quiet = 1'b0; end
      chk(quiet, "R4", "no conversion from held start", quiet, 1);
    end
  endtask

  task automatic conv(input logic [63:0] v, input logic [159:0] exp,
                      input bit hold, input bit chain,
                      input logic [63:0] nv, input string req);
    @(negedge clk);
    din = v;
    start = 1'b1;
    @(negedge clk);
    collect(v, exp, hold, chain, nv, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    din = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R5", "reset state", {out_valid, done}, 0);
    rst = 1'b0;

    // vector table: R1 values and R6 decimal boundaries
    for (int k = 0; k < NV; k++)
      conv(VIN[k], VEXP[k], 1'b0, 1'b0, 64'd0, (k < 4) ? "R1" : "R6");

    // R1 random values against the division reference
    for (int k = 0; k < 8; k++) begin
      logic [63:0] rv;
      rv = {$urandom(), $urandom()};
      conv(rv, ref_str(rv), 1'b0, 1'b0, 64'd0, "R1");
    end

    // R4: start held high with another value during the whole conversion
    conv(64'd9876543210123456789, ref_str(64'd9876543210123456789),
         1'b1, 1'b0, 64'd0, "R4");

    // R7: back-to-back start in the done cycle
    conv(64'd5, ref_str(64'd5), 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, "R7");

    // R5: reset in the middle of the byte stream
    @(negedge clk);
    din = 64'd777;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    chk(out_valid, "R2", "stream running before reset", out_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R5", "cleared after reset edge", {out_valid, done}, 0);
    rst = 1'b0;
    begin
      bit quiet = 1'b1;
      repeat (2*LAT) begin @(negedge clk); if (out_valid || done) quiet = 1'b0; end
      chk(quiet, "R5", "conversion abandoned", quiet, 1);
    end
    conv(64'd42, ref_str(64'd42), 1'b0, 1'b0, 64'd0, "R5");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule